// File: doc/BRIEF.md
# DC-Balanced Serial Lane Decoder with Clock-Lane Framing

This block is the receive half of a DC-balanced serial link. It is clocked once per serial bit time. On every clock it takes one bit from each of three data lanes and one bit from a clock lane. The clock lane repeats once every nine bit times. It rises at the start of each word, and its high time alternates between four and five bits from one word to the next. The decoder uses this clock-lane pattern to find where each word starts. Once the pattern has been seen reliably, it declares frame lock.

Each data lane carries nine bits per word: seven payload bits followed by two polarity flags, called flag A and flag B. The transmitter inverts the seven payload bits when that keeps the line balanced, and it records the choice in the flag pair. The decoder undoes any inversion for each lane separately. It joins the three restored 7-bit groups into a single 21-bit word and issues that word with a one-cycle valid strobe, once every nine bit times.

A flag pair whose two bits are equal cannot occur on a correct link. When the decoder sees one, it raises a per-lane code-error bit alongside the word, and it passes that lane's payload through unchanged.

Top module: `dcb_lane_decoder`

## Requirements
- R1: While reset is high, and on the first cycle after it, `word_valid_o`, `lock_o` and every bit of `code_err_o` are 0.
- R2: In bit times 0 to 6 of a word, lane L delivers payload bits 0 to 6, and each bit k goes to output bit `L*7+k`. Bit time 7 carries flag A and bit time 8 carries flag B.
- R3: Flags A=1, B=0 mean the lane's payload was inverted, and the decoder outputs it inverted back. Flags A=0, B=1 mean the payload is output exactly as received.
- R4: If a lane's two flags are equal (00 or 11), that lane's bit in `code_err_o` is 1 together with the valid strobe. That lane's payload is then output exactly as received.
- R5: Bit time 0 of a word is the bit in which the clock lane is 1 and was 0 in the bit before.
- R6: A period runs from one clock-lane rise to the next. A period is good when it is 9 bits long and its high time is 4 or 5. `lock_o` goes to 1 in the cycle after the rise that closes the second consecutive good period whose high times differ. No valid strobe is issued while `lock_o` is 0.
- R7: `word_o` and `code_err_o` are updated, and `word_valid_o` is 1 for exactly one cycle, in the cycle after the bit time 8 of a word that was received while locked.
- R8: Any of the following drops `lock_o` and holds off valid words until lock is regained under R6: a period that is not 9 bits long, a high time other than 4 or 5, or two consecutive periods with equal high times. A period still open after 9 bits drops `lock_o` on its tenth bit.
- R9: `code_err_o` is all zero in every cycle in which `word_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_lane_i | input | 1 | Clock-lane bit for the current bit time |
| data_lane_i | input | 3 | One bit per data lane for the current bit time |
| word_o | output | 21 | Restored parallel word; lane 0 occupies bits 6:0 |
| word_valid_o | output | 1 | One-cycle strobe, once per word while locked |
| code_err_o | output | 3 | Per-lane flag for an illegal (equal) flag pair |
| lock_o | output | 1 | Frame lock state |

## Verification
The main sweep sends 128 consecutive words. In each word the seven payload bits of one lane step through every possible value, and the other two lanes carry values derived from it. Each lane's flag mode is also stepped through plain, inverted and both illegal pairs. This sweep separates three kinds of fault: a misplaced bit or lane, a missing inversion, and an error flag raised on the wrong lane. Further stimulus checks that the lock state machine tells each kind of disturbance apart from a good pattern. The disturbances used are a repeated high time, a high time of three, and an idle gap that stretches a period. In every case the bench checks the exact word at which lock is lost and the word at which it is regained.

// File: rtl/dcb_rx_pkg.sv
package dcb_rx_pkg;
  // flag pair encodings carried in bit times 7 and 8 of each lane
  typedef enum logic [1:0] {
    FLAGS_ERR_LO = 2'b00,
    FLAGS_PLAIN  = 2'b10,  // {flag_b, flag_a} = {1,0}: sent as is
    FLAGS_INV    = 2'b01,  // {flag_b, flag_a} = {0,1}: payload inverted
    FLAGS_ERR_HI = 2'b11
  } flag_pair_e;

  // maximum count of the lock qualifier
  localparam int unsigned LOCK_GOOD = 2;
endpackage

// File: rtl/dcb_frame_tracker.sv
module dcb_frame_tracker #(
  parameter int unsigned PERIOD = 9,
  localparam int unsigned CW = $clog2(PERIOD + 2)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clk_lane_i,
  output logic [CW-1:0] bit_idx_o,
  output logic          lock_o
);
  import dcb_rx_pkg::*;

  localparam logic [CW-1:0] HI_SHORT = CW'(PERIOD / 2);
  localparam logic [CW-1:0] HI_LONG  = CW'(PERIOD - PERIOD / 2);
  localparam logic [CW-1:0] LEN      = CW'(PERIOD);
  localparam logic [CW-1:0] POS_MAX  = CW'(PERIOD + 1);

  logic          prev_q;
  logic [CW-1:0] pos_q;
  logic [CW-1:0] hcnt_q;
  logic [CW-1:0] prev_hi_q;
  logic [1:0]    good_q;
  logic          rise_w;
  logic          period_ok_w;
  logic          overrun_w;

  assign rise_w      = clk_lane_i & ~prev_q;
  assign period_ok_w = (pos_q == LEN) && ((hcnt_q == HI_SHORT) || (hcnt_q == HI_LONG));
  assign overrun_w   = ~rise_w && (pos_q == LEN);
  assign bit_idx_o   = rise_w ? '0 : pos_q;
  assign lock_o      = (good_q == 2'(LOCK_GOOD));

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q    <= 1'b1;
      pos_q     <= POS_MAX;
      hcnt_q    <= '0;
      prev_hi_q <= '0;
      good_q    <= '0;
    end else begin
      prev_q <= clk_lane_i;
      if (rise_w) begin
        pos_q     <= CW'(1);
        hcnt_q    <= CW'(1);
        prev_hi_q <= hcnt_q;
        if (period_ok_w && (good_q == '0 || hcnt_q != prev_hi_q)) begin
          if (good_q != 2'(LOCK_GOOD)) good_q <= good_q + 2'd1;
        end else if (period_ok_w) begin
          good_q <= 2'd1;
        end else begin
          good_q <= '0;
        end
      end else begin
        if (pos_q != POS_MAX) pos_q <= pos_q + CW'(1);
        if (clk_lane_i && hcnt_q != POS_MAX) hcnt_q <= hcnt_q + CW'(1);
        if (overrun_w) good_q <= '0;
      end
    end
  end

  // R6
  lock_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_o) |-> $past(rise_w));

  // R8
  lock_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(lock_o) |-> ($past(rise_w) || $past(overrun_w)));
endmodule

// File: rtl/dcb_lane_shifter.sv
module dcb_lane_shifter #(
  parameter int unsigned SYM = 9
) (
  input  logic           clk,
  input  logic           din_i,
  output logic [SYM-1:0] sym_o
);
  logic [SYM-2:0] sr_q;

  always_ff @(posedge clk) begin
    sr_q <= {din_i, sr_q[SYM-2:1]};
  end

  // oldest bit at position 0, current bit completes the symbol on top
  assign sym_o = {din_i, sr_q};
endmodule

// File: rtl/dcb_group_restore.sv
module dcb_group_restore #(
  parameter int unsigned DBITS = 7
) (
  input  logic [DBITS+1:0] sym_i,
  output logic [DBITS-1:0] data_o,
  output logic             err_o
);
  import dcb_rx_pkg::*;

  flag_pair_e flags_w;

  always_comb begin
    flags_w = flag_pair_e'(sym_i[DBITS+1:DBITS]);
    unique case (flags_w)
      FLAGS_INV: begin
        data_o = ~sym_i[DBITS-1:0];
        err_o  = 1'b0;
      end
      FLAGS_PLAIN: begin
        data_o = sym_i[DBITS-1:0];
        err_o  = 1'b0;
      end
      default: begin
        data_o = sym_i[DBITS-1:0];
        err_o  = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/dcb_lane_decoder.sv
module dcb_lane_decoder #(
  parameter int unsigned LANES = 3,
  parameter int unsigned DBITS = 7,
  localparam int unsigned SYM   = DBITS + 2,
  localparam int unsigned WORDW = LANES * DBITS,
  localparam int unsigned CW    = $clog2(SYM + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clk_lane_i,
  input  logic [LANES-1:0] data_lane_i,
  output logic [WORDW-1:0] word_o,
  output logic             word_valid_o,
  output logic [LANES-1:0] code_err_o,
  output logic             lock_o
);
  logic [CW-1:0]    bit_idx_w;
  logic             last_bit_w;
  logic [WORDW-1:0] dec_word_w;
  logic [LANES-1:0] dec_err_w;

  dcb_frame_tracker #(.PERIOD(SYM)) i_frame (
    .clk        (clk),
    .rst        (rst),
    .clk_lane_i (clk_lane_i),
    .bit_idx_o  (bit_idx_w),
    .lock_o     (lock_o)
  );

  assign last_bit_w = (bit_idx_w == CW'(SYM - 1));

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [SYM-1:0] sym_w;

    dcb_lane_shifter #(.SYM(SYM)) i_shift (
      .clk   (clk),
      .din_i (data_lane_i[l]),
      .sym_o (sym_w)
    );

    dcb_group_restore #(.DBITS(DBITS)) i_restore (
      .sym_i  (sym_w),
      .data_o (dec_word_w[l*DBITS +: DBITS]),
      .err_o  (dec_err_w[l])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_o       <= '0;
      word_valid_o <= 1'b0;
      code_err_o   <= '0;
    end else if (lock_o && last_bit_w) begin
      word_o       <= dec_word_w;
      word_valid_o <= 1'b1;
      code_err_o   <= dec_err_w;
    end else begin
      word_valid_o <= 1'b0;
      code_err_o   <= '0;
    end
  end

  // R7
  valid_locked_chk: assert property (@(posedge clk) disable iff (rst)
    word_valid_o |-> lock_o);

  // R7
  valid_single_chk: assert property (@(posedge clk) disable iff (rst)
    word_valid_o |=> !word_valid_o);

  // R9
  err_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (code_err_o != '0) |-> word_valid_o);
endmodule

// File: tb/test_dcb_lane_decoder.sv
module test_dcb_lane_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clk_lane = 1'b0;
  logic [2:0]  data_lane = '0;
  logic [20:0] word;
  logic        word_valid;
  logic [2:0]  code_err;
  logic        lock;

  int errors = 0;
  int checks = 0;

  // bench model of framing, built from R5, R6 and R8
  int m_len = 99, m_high = 0, m_prev_high = 0, m_cnt = 0;
  logic m_prev_bit = 1'b1;
  logic        pend = 1'b0, pend_v = 1'b0;
  logic [20:0] pend_d, next_d;
  logic [2:0]  pend_e, next_e;

  always #2ns clk = ~clk;

  dcb_lane_decoder i_dcb_lane_decoder (
    .clk          (clk),
    .rst          (rst),
    .clk_lane_i   (clk_lane),
    .data_lane_i  (data_lane),
    .word_o       (word),
    .word_valid_o (word_valid),
    .code_err_o   (code_err),
    .lock_o       (lock)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic drive_bit(input logic cb, input logic [2:0] lanes);
    bit rise;
    int idx;
    @(negedge clk);
    if (pend) begin
      check(word_valid == pend_v, "R6 R7 valid", 32'(word_valid), 32'(pend_v));
      if (pend_v) begin
        check(word == pend_d, "R2 R3 R5 word", 32'(word), 32'(pend_d));
        check(code_err == pend_e, "R4 code error", 32'(code_err), 32'(pend_e));
      end else begin
        check(code_err == 3'b0, "R9 error without valid", 32'(code_err), 0);
      end
      pend = 1'b0;
    end else begin
      check(word_valid == 1'b0, "R7 valid outside word end", 32'(word_valid), 0);
    end
    check(lock == (m_cnt == 2), "R6 R8 lock", 32'(lock), 32'(m_cnt == 2));
    rise = cb && !m_prev_bit;
    idx  = rise ? 0 : m_len;
    if (idx == 8) begin
      pend = 1'b1; pend_v = (m_cnt == 2); pend_d = next_d; pend_e = next_e;
    end
    if (rise) begin
      bit ok;
      ok = (m_len == 9) && (m_high == 4 || m_high == 5);
      if (ok && (m_cnt == 0 || m_high != m_prev_high)) m_cnt = (m_cnt < 2) ? m_cnt + 1 : 2;
      else if (ok) m_cnt = 1;
      else m_cnt = 0;
      m_prev_high = m_high;
      m_len = 1; m_high = 1;
    end else begin
      if (m_len == 9) m_cnt = 0;
      if (m_len < 10) m_len++;
      if (cb && m_high < 10) m_high++;
    end
    m_prev_bit = cb;
    clk_lane  = cb;
    data_lane = lanes;
  endtask

  // mode per lane: 0 plain (A=0,B=1), 1 inverted (A=1,B=0), 2 flags 00, 3 flags 11
  task automatic send_word(input logic [20:0] d, input logic [5:0] mode, input int high);
    logic [8:0] sym [3];
    for (int l = 0; l < 3; l++) begin
      logic [6:0] g;
      logic [1:0] m;
      g = d[l*7 +: 7];
      m = mode[l*2 +: 2];
      case (m)
        2'd0: sym[l] = {1'b1, 1'b0, g};
        2'd1: sym[l] = {1'b0, 1'b1, ~g};
        2'd2: sym[l] = {1'b0, 1'b0, g};
        default: sym[l] = {1'b1, 1'b1, g};
      endcase
      next_e[l] = m[1];
    end
    next_d = d;
    for (int b = 0; b < 9; b++)
      drive_bit(b < high, {sym[2][b], sym[1][b], sym[0][b]});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive_bit(1'b0, 3'b000);
  endtask

  initial begin
    #(4ns * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int hi;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1
    check(word_valid == 1'b0 && lock == 1'b0 && code_err == 3'b0, "R1 reset state",
          {29'b0, word_valid, lock, |code_err}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(word_valid == 1'b0 && lock == 1'b0, "R1 after reset", {30'b0, word_valid, lock}, 0);
    idle(3);
    hi = 4;
    // main sweep: every payload value, every flag mode
    for (int v = 0; v < 128; v++) begin
      logic [6:0] a;
      a = 7'(v);
      send_word({~a, a ^ 7'h5a, a}, 6'(v * 7), hi);
      hi = 9 - hi;
    end
    // R8: repeated high time
    send_word(21'h12345, 6'b000100, hi);
    send_word(21'h0abcd, 6'b010001, hi);
    for (int i = 0; i < 4; i++) begin
      hi = 9 - hi;
      send_word(21'(i * 21'h2f1e3), 6'(i), hi);
    end
    // R8: high time of three
    send_word(21'h1f0f0, 6'b0, 3);
    hi = 4;
    for (int i = 0; i < 4; i++) begin
      send_word(21'(21'h15555 ^ i), 6'b100100, hi);
      hi = 9 - hi;
    end
    // R8: idle gap stretches the period past nine bits
    idle(12);
    for (int i = 0; i < 5; i++) begin
      send_word(21'(21'h0f00f + i * 77), 6'b111001, hi);
      hi = 9 - hi;
    end
    idle(3);
    summary();
  end
endmodule